// File: doc/BRIEF.md
# XML Line-Ending Normalizer

This block applies the XML 1.0 end-of-line rule to a stream of bytes that arrives as a block of several bytes per clock. Each lane of the block is classified in parallel as carriage return (CR, 0x0D), line feed (LF, 0x0A) or an illegal control byte. Shift-and-mask logic over the whole block then finds every CR-LF pair. One bit of state carries a CR from the last lane of one block into the first lane of the next.

The block writes every CR as an LF. It marks the LF half of each CR-LF pair in a per-lane deletion mask, so exactly one line feed survives each pair. It does not remove any bytes itself. The mask is meant to be OR-combined with the masks of other stages, and a later compaction stage performs the removal. A per-lane error flag reports control bytes that XML does not allow. An end-of-input marker on the last block clears the carried CR state, so the next stream starts clean.

Top module: `xeol_norm`

## Requirements
- R1: Lane 0 is the earliest byte of a block and sits in `in_data[7:0]`; lane i sits in bits `[8*i+7:8*i]`. Every byte other than 0x0D leaves in its own lane with its value unchanged.
- R2: Every 0x0D byte leaves its lane as 0x0A, whether or not an LF follows it and whether or not it is the last byte of the input.
- R3: When lane i (i >= 1) holds 0x0A and lane i-1 of the same block holds 0x0D, `out_del[i]` is 1 and the CR lane's `out_del` bit is 0. Of each pair, only the LF position is marked.
- R4: When lane 0 holds 0x0A and the last lane of the previously accepted block held 0x0D, `out_del[0]` is 1. This holds even if idle cycles separate the two blocks.
- R5: A block accepted with `in_last` = 1 ends the stream. An LF in lane 0 of the next block is not marked for deletion, even if the last block ended in 0x0D.
- R6: `out_del` is 0 for every lane that does not hold an LF directly preceded by a CR in the stream.
- R7: `out_ctl_err[i]` is 1 exactly when the lane holds a byte in 0x00..0x1F other than 0x09, 0x0A and 0x0D.
- R8: With the default registered output, `out_valid` follows `in_valid` by one clock, and outputs appear on that clock. While `out_valid` is 0, `out_del` and `out_ctl_err` are all zero.
- R9: During reset and after it, `out_valid` is 0 and the carried CR state is clear. An LF in lane 0 of the first block after reset is not marked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block is presented on `in_data` this cycle |
| in_last | input | 1 | This block is the final block of its stream |
| in_data | input | 8*LANES | Byte block, lane 0 in the low byte |
| out_valid | output | 1 | Output block is valid |
| out_data | output | 8*LANES | Block with every CR written as LF |
| out_del | output | LANES | Per-lane deletion mask (LF half of CR-LF pairs) |
| out_ctl_err | output | LANES | Per-lane illegal control byte flag |

## Verification
A four-lane instance is driven with every one of the 625 blocks built from the symbols CR, LF, a letter, 0x01 and tab. Consecutive blocks therefore end and begin in every combination. This separates pairs inside a block from pairs split across a block edge, and it separates isolated CRs from paired ones. It also separates legal from illegal control bytes. End-of-stream markers and idle gaps are scattered through the sweep, so they check that stream end clears the carried CR and that idle cycles do not. Directed blocks around a mid-run reset check that reset clears the carried CR state.

// File: rtl/xeol_pkg.sv
package xeol_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam logic [BYTE_W-1:0] CHR_TAB  = 8'h09;
   localparam logic [BYTE_W-1:0] CHR_LF   = 8'h0A;
   localparam logic [BYTE_W-1:0] CHR_CR   = 8'h0D;
   localparam logic [BYTE_W-1:0] CTL_LAST = 8'h1F;

   typedef struct packed {
      logic cr;
      logic lf;
      logic bad;
   } lane_cls_t;
endpackage

// File: rtl/xeol_lane_class.sv
module xeol_lane_class
   import xeol_pkg::*;
(
   input  logic [BYTE_W-1:0] byte_i,
   output lane_cls_t         cls_o,
   output logic [BYTE_W-1:0] byte_o
);
   logic is_ctl;

   always_comb begin
      is_ctl     = (byte_i <= CTL_LAST);
      cls_o.cr   = (byte_i == CHR_CR);
      cls_o.lf   = (byte_i == CHR_LF);
      cls_o.bad  = is_ctl && (byte_i != CHR_TAB) && !cls_o.cr && !cls_o.lf;
      // every CR leaves as LF: paired ones keep their CR slot, lone ones too
      byte_o     = cls_o.cr ? CHR_LF : byte_i;
   end
endmodule

// File: rtl/xeol_mask.sv
module xeol_mask #(
   parameter int unsigned LANES = 8
) (
   input  logic [LANES-1:0] cr_v,
   input  logic [LANES-1:0] lf_v,
   input  logic             carry_i,
   output logic [LANES-1:0] del_v,
   output logic             carry_o
);
   logic [LANES-1:0] cr_prev_v;

   // position i sees whether position i-1 (or the previous block's tail) was CR
   assign cr_prev_v = {cr_v[LANES-2:0], carry_i};
   assign del_v     = lf_v & cr_prev_v;
   assign carry_o   = cr_v[LANES-1];
endmodule

// File: rtl/xeol_norm.sv
module xeol_norm
   import xeol_pkg::*;
#(
   parameter int unsigned LANES   = 8,
   parameter int unsigned OUT_REG = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_last,
   input  logic [LANES*BYTE_W-1:0] in_data,
   output logic                    out_valid,
   output logic [LANES*BYTE_W-1:0] out_data,
   output logic [LANES-1:0]        out_del,
   output logic [LANES-1:0]        out_ctl_err
);
   localparam int unsigned DATA_W = LANES * BYTE_W;

   if (LANES < 2) begin : g_bad_lanes
      $error("xeol_norm: LANES must be at least 2");
   end
   if (OUT_REG > 1) begin : g_bad_outreg
      $error("xeol_norm: OUT_REG must be 0 or 1");
   end

   logic [LANES-1:0]  cr_v, lf_v, bad_v, del_v;
   logic [DATA_W-1:0] fix_data;
   logic              carry_q, carry_nxt;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      lane_cls_t cls;
      xeol_lane_class u_cls (
         .byte_i (in_data[i*BYTE_W +: BYTE_W]),
         .cls_o  (cls),
         .byte_o (fix_data[i*BYTE_W +: BYTE_W])
      );
      assign cr_v[i]  = cls.cr;
      assign lf_v[i]  = cls.lf;
      assign bad_v[i] = cls.bad;
   end

   xeol_mask #(.LANES(LANES)) u_mask (
      .cr_v    (cr_v),
      .lf_v    (lf_v),
      .carry_i (carry_q),
      .del_v   (del_v),
      .carry_o (carry_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         carry_q <= 1'b0;
      end else if (in_valid) begin
         carry_q <= in_last ? 1'b0 : carry_nxt;
      end
   end

   if (OUT_REG == 1) begin : g_reg_out
      logic              v_q;
      logic [DATA_W-1:0] d_q;
      logic [LANES-1:0]  del_q, err_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q   <= 1'b0;
            d_q   <= '0;
            del_q <= '0;
            err_q <= '0;
         end else begin
            v_q   <= in_valid;
            d_q   <= fix_data;
            del_q <= in_valid ? del_v : '0;
            err_q <= in_valid ? bad_v : '0;
         end
      end
      assign out_valid   = v_q;
      assign out_data    = d_q;
      assign out_del     = del_q;
      assign out_ctl_err = err_q;
   end else begin : g_comb_out
      assign out_valid   = in_valid;
      assign out_data    = fix_data;
      assign out_del     = in_valid ? del_v : '0;
      assign out_ctl_err = in_valid ? bad_v : '0;
   end
endmodule

// File: rtl/xeol_norm_chk.sv
module xeol_norm_chk
   import xeol_pkg::*;
#(
   parameter int unsigned LANES   = 8,
   parameter int unsigned OUT_REG = 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    out_valid,
   input logic [LANES*BYTE_W-1:0] out_data,
   input logic [LANES-1:0]        out_del,
   input logic [LANES-1:0]        out_ctl_err
);
   logic [LANES-1:0] lf_out, cr_out;

   for (genvar i = 0; i < LANES; i++) begin : g_obs
      assign lf_out[i] = (out_data[i*BYTE_W +: BYTE_W] == CHR_LF);
      assign cr_out[i] = (out_data[i*BYTE_W +: BYTE_W] == CHR_CR);
   end

   AST_NO_CR_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (cr_out == '0));                                  // R2
   AST_DEL_ONLY_LF: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_del & ~lf_out) == '0));                     // R3
   AST_DEL_NOT_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_del & (out_del >> 1)) == '0));              // R6
   AST_ERR_NOT_DEL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_ctl_err & out_del) == '0));                 // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_del == '0 && out_ctl_err == '0));           // R8

   if (OUT_REG == 1) begin : g_lat
      AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);                                     // R8
      AST_IDLE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);                                   // R8
   end else begin : g_nolat
      AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |-> out_valid);                                     // R8
   end
endmodule

bind xeol_norm xeol_norm_chk #(.LANES(LANES), .OUT_REG(OUT_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .out_valid   (out_valid),
   .out_data    (out_data),
   .out_del     (out_del),
   .out_ctl_err (out_ctl_err)
);

// File: tb/tb_xeol_norm.sv
module tb_xeol_norm;
   localparam int LN = 4;
   localparam int DW = LN * 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_last = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_valid;
   logic [DW-1:0] out_data;
   logic [LN-1:0] out_del, out_ctl_err;

   int vectors = 0;
   int misses = 0;
   logic prev_cr = 1'b0;

   always #2.5 clk = ~clk;

   xeol_norm #(.LANES(LN), .OUT_REG(1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
      .out_del(out_del), .out_ctl_err(out_ctl_err)
   );

   function automatic logic [7:0] sym(input int k);
      case (k)
         0: sym = 8'h0D;
         1: sym = 8'h0A;
         2: sym = 8'h61;
         3: sym = 8'h01;
         default: sym = 8'h09;
      endcase
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [DW-1:0] got,
                      input logic [DW-1:0] exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   // Drives one cycle at a negedge and checks the registered result one cycle later.
   task automatic apply(input logic v, input logic l, input logic [DW-1:0] d, input string tag);
      logic [DW-1:0] ed;
      logic [LN-1:0] edel, eerr;
      logic pc;
      logic [7:0] b;
      in_valid = v; in_last = l; in_data = d;
      pc = prev_cr; ed = d; edel = '0; eerr = '0;
      if (v) begin
         for (int i = 0; i < LN; i++) begin
            b = d[i*8 +: 8];
            ed[i*8 +: 8] = (b == 8'h0D) ? 8'h0A : b;
            edel[i] = (b == 8'h0A) && pc;
            eerr[i] = (b < 8'h20) && (b != 8'h09) && (b != 8'h0A) && (b != 8'h0D);
            pc = (b == 8'h0D);
         end
         prev_cr = l ? 1'b0 : pc;
      end
      @(negedge clk);
      chk(out_valid == v, {tag, " R8 valid"}, DW'(out_valid), DW'(v));
      if (v) chk(out_data == ed, {tag, " R1 R2 data"}, out_data, ed);
      chk(out_del == edel, {tag, " R3 R4 R5 R6 del"}, DW'(out_del), DW'(edel));
      chk(out_ctl_err == eerr, {tag, " R7 err"}, DW'(out_ctl_err), DW'(eerr));
   endtask

   initial begin
      #500000;
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      chk(out_valid == 1'b0, "R9 valid in reset", DW'(out_valid), '0);
      rst_n = 1'b1;
      // R9: LF in lane 0 right after reset is not deleted
      apply(1'b1, 1'b0, {8'h61, 8'h0D, 8'h61, 8'h0A}, "R9 first block");
      // R4: CR tail, idle gap, LF head
      apply(1'b1, 1'b0, {8'h0D, 8'h61, 8'h61, 8'h61}, "R4 tail CR");
      apply(1'b0, 1'b0, '0, "R8 idle");
      apply(1'b1, 1'b0, {8'h61, 8'h61, 8'h0D, 8'h0A}, "R4 head LF");
      // R5: CR at end of input is rewritten; next stream keeps its LF
      apply(1'b1, 1'b1, {8'h0D, 8'h0A, 8'h0D, 8'h61}, "R5 last CR");
      apply(1'b1, 1'b0, {8'h0A, 8'h0A, 8'h61, 8'h0A}, "R5 new stream");
      // R10-style lane order: CR in lane 1, LF in lane 0 is no pair (R1 R3)
      apply(1'b1, 1'b0, {8'h61, 8'h61, 8'h0D, 8'h0A}, "R1 lane order");
      // full sweep over five symbols in four lanes
      for (int n = 0; n < 625; n++) begin
         logic [DW-1:0] d;
         int r;
         r = n;
         for (int i = 0; i < LN; i++) begin
            d[i*8 +: 8] = sym(r % 5);
            r = r / 5;
         end
         if (n % 11 == 10) apply(1'b0, 1'b0, '0, "R8 gap");
         apply(1'b1, (n % 37) == 36, d, "sweep");
      end
      // R9: reset in mid-stream after a CR tail clears the carry
      apply(1'b1, 1'b0, {8'h0D, 8'h61, 8'h61, 8'h61}, "R9 pre-reset");
      rst_n = 1'b0; in_valid = 1'b0; prev_cr = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 valid in reset", DW'(out_valid), '0);
      rst_n = 1'b1;
      apply(1'b1, 1'b0, {8'h61, 8'h61, 8'h61, 8'h0A}, "R9 after reset");
      apply(1'b0, 1'b0, '0, "R8 drain");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule